// File: doc/BRIEF.md
# Calendar time-of-day counter

This block holds wall-clock time and date as eight bytes in an indexed register space. The bytes are seconds, minutes, hours, day of month, month, two-digit year, century, and one control byte. Software first writes an index, then reads or writes the data byte at that index. A one-cycle `sec_pulse` from an external divider asks the block to advance the time by one second. The step carries through every field, including month lengths and leap years, up to the century.

The control byte picks how the time bytes are encoded and whether the clock runs. Values can be binary or packed BCD. Hours can be 24-hour or 12-hour; in 12-hour form bit 7 of the hour byte is a PM flag. The same counter chain serves every format: each field is decoded to binary, stepped, and encoded back. While the halt bit is set, pulses are discarded and software can load the time freely.

Top module: `cal_tod_regs`

## Requirements
- R1: After synchronous reset the control byte (index 0x0b) reads 0x86, meaning halted, binary and 24-hour. Seconds, minutes and hours read 0, day and month read 1, year reads 0 and century reads 20 (0x14).
- R2: When `addr_wr` is high for a cycle, `wdata` becomes the index. A `data_rd` cycle then puts the indexed byte on `rdata` at the next clock edge. Time fields sit at seconds 0x00, minutes 0x02, hours 0x04, day 0x07, month 0x08, year 0x09 and century 0x32. Any other index except 0x0b reads 0, and writes to it are ignored.
- R3: With control bit 2 set (binary), seconds and minutes count 0..59. On a wrap the next field up advances by one.
- R4: With control bit 2 clear (BCD), every field counts in packed BCD. For example, seconds go 0x09 to 0x10, and 0x19:0x59 (minutes:seconds) becomes 0x20:0x00.
- R5: With control bit 1 set (24-hour), hours count 0..23. A step from 23:59:59 gives 00:00:00 and advances the day.
- R6: With control bit 1 clear (12-hour), hours run 12, 1, ..., 11, and bit 7 of the hour byte marks PM. 12 AM is 12 with bit 7 clear. In BCD, 0x11 steps to 0x92, 0x12 steps to 0x01, and 0x92 steps to 0x81. 0x91 steps to 0x12 and advances the day. In binary, 0x0B steps to 0x8C.
- R7: After the last day of its month, the day returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, month 2 has 28 or 29, and all others have 31.
- R8: February has 29 days when the year is a nonzero multiple of 4, or when the year is 0 and the century is a multiple of 4.
- R9: A year step from 99 gives 00 and advances the century, in either format. December 31 rolls to January 1.
- R10: While control bit 7 (halt) is set, `sec_pulse` has no effect and pulses are not saved for later. Time fields still accept writes.
- R11: A data write takes effect at the next edge. If a pulse arrives in a cycle with a data write, the one-second step is applied in the first later cycle with no data write, so it acts on the written value.
- R12: After the halt bit is cleared with the time at 00:00:00, the first pulse makes seconds read 1 and the second makes them read 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_pulse | input | 1 | One-cycle request to advance one second |
| addr_wr | input | 1 | Load `wdata` as the register index |
| data_wr | input | 1 | Write `wdata` to the indexed register |
| data_rd | input | 1 | Capture the indexed register into `rdata` |
| wdata | input | 8 | Index or data byte from software |
| rdata | output | 8 | Registered read data |

## Verification
Internal state reaches the ports only through `rdata`. A wrong byte is therefore seen one edge after the read that selects it, and not before software asks for it. Carry faults stay hidden until a pulse crosses that field's limit, so the bench loads each boundary value (59, 23, 11 and 12 in 12-hour form, month ends, February, year 99) just before a single pulse. It then reads the field and all its neighbours. A fault in the deferral of a pulse that collides with a write shows as a seconds value that is off by one on the next read.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef logic [7:0] cal_byte_t;

  localparam int NF     = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_CEN  = 6;

  function automatic cal_byte_t bcd2bin(input cal_byte_t v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic cal_byte_t bin2bcd(input cal_byte_t b);
    cal_byte_t t, o;
    t = b / 8'd10;
    o = b % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction
endpackage

// File: rtl/cal_wrap_step.sv
module cal_wrap_step #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (!en)            nxt = cur;
    else if (cur >= hi) nxt = lo;
    else                nxt = cur + W'(1);
  end
endmodule

// File: rtl/cal_hour_codec.sv
module cal_hour_codec
  import cal_pkg::*;
(
  input  cal_byte_t stored,
  input  logic      bin,
  input  logic      mode24,
  input  cal_byte_t nxt24,
  output cal_byte_t cur24,
  output cal_byte_t enc
);
  cal_byte_t v, vb, h12, h12e;
  logic      pm, pmn;

  always_comb begin
    pm  = stored[7];
    v   = mode24 ? stored : {1'b0, stored[6:0]};
    vb  = bin ? v : bcd2bin(v);
    if (mode24)          cur24 = vb;
    else if (vb == 8'd12) cur24 = pm ? 8'd12 : 8'd0;
    else                 cur24 = pm ? vb + 8'd12 : vb;

    pmn  = (nxt24 >= 8'd12);
    if (nxt24 == 8'd0)      h12 = 8'd12;
    else if (nxt24 > 8'd12) h12 = nxt24 - 8'd12;
    else                    h12 = nxt24;
    h12e = bin ? h12 : bin2bcd(h12);
    if (mode24) enc = bin ? nxt24 : bin2bcd(nxt24);
    else        enc = {pmn, h12e[6:0]};
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  cal_byte_t month,
  input  cal_byte_t year,
  input  cal_byte_t century,
  output cal_byte_t last_day
);
  logic leap;

  always_comb begin
    leap = (year != 8'd0) ? (year[1:0] == 2'b00) : (century[1:0] == 2'b00);
    case (month)
      8'd2:                      last_day = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   last_day = 8'd30;
      default:                   last_day = 8'd31;
    endcase
  end
endmodule

// File: rtl/cal_tod_regs.sv
module cal_tod_regs
  import cal_pkg::*;
#(
  parameter cal_byte_t IDX_SEC  = 8'h00,
  parameter cal_byte_t IDX_MIN  = 8'h02,
  parameter cal_byte_t IDX_HOUR = 8'h04,
  parameter cal_byte_t IDX_DAY  = 8'h07,
  parameter cal_byte_t IDX_MON  = 8'h08,
  parameter cal_byte_t IDX_YEAR = 8'h09,
  parameter cal_byte_t IDX_CEN  = 8'h32,
  parameter cal_byte_t IDX_CTL  = 8'h0b,
  parameter cal_byte_t RST_CTL  = 8'h86,
  parameter cal_byte_t RST_CEN  = 8'd20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_pulse,
  input  logic       addr_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam cal_byte_t FLD_IDX [NF] = '{IDX_SEC, IDX_MIN, IDX_HOUR, IDX_DAY,
                                         IDX_MON, IDX_YEAR, IDX_CEN};
  localparam cal_byte_t FLD_LO  [NF] = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0};
  localparam cal_byte_t FLD_HI  [NF] = '{8'd59, 8'd59, 8'd23, 8'd31, 8'd12, 8'd99, 8'd99};
  localparam cal_byte_t FLD_RST [NF] = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, RST_CEN};

  cal_byte_t   idx_q, ctl_q, rdata_q, rd_mux;
  cal_byte_t   fld_q [NF];
  cal_byte_t   cur_b [NF];
  cal_byte_t   nxt_b [NF];
  cal_byte_t   enc_b [NF];
  cal_byte_t   hi_b  [NF];
  cal_byte_t   hr24, hr_enc, dim;
  logic [NF-1:0] step_en;
  logic        pend_q, adv, halt, bin, mode24;

  assign halt   = ctl_q[7];
  assign bin    = ctl_q[2];
  assign mode24 = ctl_q[1];
  assign adv    = (sec_pulse | pend_q) & ~data_wr & ~halt;
  assign step_en[0] = adv;

  cal_hour_codec u_hour (
    .stored (fld_q[F_HOUR]),
    .bin    (bin),
    .mode24 (mode24),
    .nxt24  (nxt_b[F_HOUR]),
    .cur24  (hr24),
    .enc    (hr_enc)
  );

  cal_month_len u_mlen (
    .month    (cur_b[F_MON]),
    .year     (cur_b[F_YEAR]),
    .century  (cur_b[F_CEN]),
    .last_day (dim)
  );

  for (genvar i = 0; i < NF; i++) begin : g_fld
    if (i == F_HOUR) begin : g_hr
      assign cur_b[i] = hr24;
      assign enc_b[i] = hr_enc;
    end else begin : g_plain
      assign cur_b[i] = bin ? fld_q[i] : bcd2bin(fld_q[i]);
      assign enc_b[i] = bin ? nxt_b[i] : bin2bcd(nxt_b[i]);
    end
    if (i == F_DAY) begin : g_dim
      assign hi_b[i] = dim;
    end else begin : g_fix
      assign hi_b[i] = FLD_HI[i];
    end
    if (i < NF - 1) begin : g_carry
      assign step_en[i+1] = step_en[i] && (cur_b[i] >= hi_b[i]);
    end
    cal_wrap_step #(.W(8)) u_step (
      .en  (step_en[i]),
      .cur (cur_b[i]),
      .lo  (FLD_LO[i]),
      .hi  (hi_b[i]),
      .nxt (nxt_b[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (idx_q == IDX_CTL) rd_mux = ctl_q;
    for (int k = 0; k < NF; k++)
      if (idx_q == FLD_IDX[k]) rd_mux = fld_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      ctl_q   <= RST_CTL;
      pend_q  <= 1'b0;
      rdata_q <= '0;
      for (int k = 0; k < NF; k++) fld_q[k] <= FLD_RST[k];
    end else begin
      if (addr_wr) idx_q <= wdata;
      pend_q <= (sec_pulse | pend_q) & data_wr & ~halt;
      if (data_wr && idx_q == IDX_CTL) ctl_q <= wdata;
      for (int k = 0; k < NF; k++) begin
        if (data_wr && idx_q == FLD_IDX[k]) fld_q[k] <= wdata;
        else if (step_en[k])                fld_q[k] <= enc_b[k];
      end
      if (data_rd) rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cal_tod_chk.sv
module cal_tod_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_pulse,
  input logic       data_wr,
  input logic       adv,
  input logic       halt,
  input logic       bin,
  input logic       mode24,
  input logic       pend,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hr_q
);
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt && !data_wr |=> $stable(sec_q) && $stable(min_q) && $stable(hr_q));

  // R10
  halt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !pend);

  // R11
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse && data_wr && !halt |=> pend);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse && !pend && !data_wr |=> $stable(sec_q) && $stable(min_q));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    adv && bin && sec_q == 8'd59 |=> sec_q == 8'd0);

  // R6
  noon_chk: assert property (@(posedge clk) disable iff (rst)
    adv && !bin && !mode24 && hr_q == 8'h11 && min_q == 8'h59 && sec_q == 8'h59
    |=> hr_q == 8'h92);
endmodule

bind cal_tod_regs cal_tod_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sec_pulse (sec_pulse),
  .data_wr   (data_wr),
  .adv       (adv),
  .halt      (halt),
  .bin       (bin),
  .mode24    (mode24),
  .pend      (pend_q),
  .sec_q     (fld_q[0]),
  .min_q     (fld_q[1]),
  .hr_q      (fld_q[2])
);

// File: tb/cal_tod_regs_tb.sv
`timescale 1ns/1ps
module cal_tod_regs_tb;
  localparam logic [7:0] I_SEC = 8'h00, I_MIN = 8'h02, I_HR = 8'h04, I_DAY = 8'h07,
                         I_MON = 8'h08, I_YR = 8'h09, I_CEN = 8'h32, I_CTL = 8'h0b;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_pulse = 1'b0, addr_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_d = 1'b0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  cal_tod_regs u_dut (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .addr_wr(addr_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) rd_d <= data_rd;

  // monitor: compares each captured read against the scoreboard head
  always @(negedge clk) begin
    if (rd_d && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    cyc(); addr_wr = 1'b1; wdata = idx;
    cyc(); addr_wr = 1'b0; data_wr = 1'b1; wdata = val;
    cyc(); data_wr = 1'b0;
  endtask

  task automatic wr_pulse(input logic [7:0] idx, input logic [7:0] val);
    cyc(); addr_wr = 1'b1; wdata = idx;
    cyc(); addr_wr = 1'b0; data_wr = 1'b1; wdata = val; sec_pulse = 1'b1;
    cyc(); data_wr = 1'b0; sec_pulse = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    cyc(); addr_wr = 1'b1; wdata = idx;
    cyc(); addr_wr = 1'b0; data_rd = 1'b1;
    q_exp.push_back(exp); q_tag.push_back(tag);
    cyc(); data_rd = 1'b0;
  endtask

  task automatic pulse();
    cyc(); sec_pulse = 1'b1;
    cyc(); sec_pulse = 1'b0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(I_HR, h); wr(I_MIN, m); wr(I_SEC, s);
  endtask

  task automatic set_date(input logic [7:0] c, input logic [7:0] y,
                          input logic [7:0] mo, input logic [7:0] d);
    wr(I_CEN, c); wr(I_YR, y); wr(I_MON, mo); wr(I_DAY, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    rd(I_CTL, 8'h86, "R1 ctl");
    rd(I_SEC, 8'h00, "R1 sec");
    rd(I_HR,  8'h00, "R1 hour");
    rd(I_DAY, 8'h01, "R1 day");
    rd(I_MON, 8'h01, "R1 month");
    rd(I_CEN, 8'h14, "R1 century");
    // R2 unmapped index
    rd(8'h05, 8'h00, "R2 unmapped read");
    wr(8'h05, 8'hAA);
    rd(8'h05, 8'h00, "R2 unmapped write ignored");
    // R10 halted: writes land, pulses do nothing
    wr(I_SEC, 8'd40);
    rd(I_SEC, 8'd40, "R10 write while halted");
    pulse();
    rd(I_SEC, 8'd40, "R10 pulse ignored");
    pulse();
    wr(I_SEC, 8'd0);
    // R12 release from halt, binary 24h
    wr(I_CTL, 8'h06);
    rd(I_SEC, 8'd0, "R10 no saved pulse");
    pulse(); rd(I_SEC, 8'd1, "R12 first");
    pulse(); rd(I_SEC, 8'd2, "R12 second");
    // R3 binary sec/min carry
    set_hms(8'd5, 8'd59, 8'd59); pulse();
    rd(I_SEC, 8'd0, "R3 sec"); rd(I_MIN, 8'd0, "R3 min"); rd(I_HR, 8'd6, "R3 hour");
    // R5 day carry from 23:59:59
    set_date(8'd20, 8'd23, 8'd3, 8'd10); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_HR, 8'd0, "R5 hour"); rd(I_DAY, 8'd11, "R5 day");
    // R7 month lengths
    set_date(8'd20, 8'd23, 8'd4, 8'd30); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_DAY, 8'd1, "R7 apr day"); rd(I_MON, 8'd5, "R7 apr month");
    set_date(8'd20, 8'd23, 8'd1, 8'd30); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_DAY, 8'd31, "R7 jan 31"); rd(I_MON, 8'd1, "R7 jan month");
    set_date(8'd20, 8'd23, 8'd2, 8'd28); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_DAY, 8'd1, "R7 feb day"); rd(I_MON, 8'd3, "R7 feb month");
    // R8 leap rules
    set_date(8'd20, 8'd24, 8'd2, 8'd28); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_DAY, 8'd29, "R8 year 24");
    set_date(8'd20, 8'd0, 8'd2, 8'd28); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_DAY, 8'd29, "R8 century 20");
    set_date(8'd19, 8'd0, 8'd2, 8'd28); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_DAY, 8'd1, "R8 century 19 day"); rd(I_MON, 8'd3, "R8 century 19 month");
    // R9 binary year rollover
    set_date(8'd19, 8'd99, 8'd12, 8'd31); set_hms(8'd23, 8'd59, 8'd59); pulse();
    rd(I_YR, 8'd0, "R9 year"); rd(I_CEN, 8'd20, "R9 century");
    rd(I_MON, 8'd1, "R9 month"); rd(I_DAY, 8'd1, "R9 day");
    // BCD 24h
    wr(I_CTL, 8'h02);
    set_date(8'h19, 8'h99, 8'h12, 8'h31); set_hms(8'h23, 8'h59, 8'h59); pulse();
    rd(I_YR, 8'h00, "R9 bcd year"); rd(I_CEN, 8'h20, "R9 bcd century");
    rd(I_MON, 8'h01, "R9 bcd month"); rd(I_HR, 8'h00, "R9 bcd hour");
    // R4 BCD digit carries
    set_hms(8'h10, 8'h00, 8'h09); pulse();
    rd(I_SEC, 8'h10, "R4 sec 09");
    set_hms(8'h10, 8'h19, 8'h59); pulse();
    rd(I_MIN, 8'h20, "R4 min"); rd(I_SEC, 8'h00, "R4 sec");
    // R6 12-hour BCD
    wr(I_CTL, 8'h00);
    set_hms(8'h11, 8'h59, 8'h59); pulse();
    rd(I_HR, 8'h92, "R6 noon"); rd(I_MIN, 8'h00, "R6 noon min"); rd(I_SEC, 8'h00, "R6 noon sec");
    set_hms(8'h12, 8'h59, 8'h59); pulse();
    rd(I_HR, 8'h01, "R6 12am");
    set_hms(8'h92, 8'h59, 8'h59); pulse();
    rd(I_HR, 8'h81, "R6 12pm");
    set_date(8'h20, 8'h23, 8'h03, 8'h05); set_hms(8'h91, 8'h59, 8'h59); pulse();
    rd(I_HR, 8'h12, "R6 midnight"); rd(I_DAY, 8'h06, "R6 midnight day");
    wr(I_CTL, 8'h04);
    set_hms(8'h0B, 8'd59, 8'd59); pulse();
    rd(I_HR, 8'h8C, "R6 binary noon");
    // R11 write/pulse collision, binary 24h
    wr(I_CTL, 8'h06);
    set_hms(8'd1, 8'd3, 8'd5);
    wr_pulse(I_MIN, 8'd30);
    rd(I_MIN, 8'd30, "R11 min written"); rd(I_SEC, 8'd6, "R11 deferred step");
    wr_pulse(I_SEC, 8'd10);
    rd(I_SEC, 8'd11, "R11 step after sec write");
    wr(I_MIN, 8'd45);
    rd(I_MIN, 8'd45, "R11 immediate"); rd(I_SEC, 8'd11, "R11 no extra step");
    repeat (4) cyc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule